// File: doc/BRIEF.md
# Weight Fault Scrub Stage

This stage closes the weight-fetch step of a neural-network datapath. Each cycle it may receive one signed weight word read from a memory run at reduced supply voltage, plus a flag vector that marks, bit by bit, which columns of that read are suspected to be wrong. The stage masks the suspect data and registers the result, so that a bad read pulls the weight toward zero and never reaches the multiplier as a large error.

The per-word policy comes from a two-bit mode input. Pass mode leaves the data as read. Word mode zeroes any word that has a flag set. Bit mode copies the sign bit into each flagged bit position. A fourth mode works like bit mode but zeroes the word when the sign bit's own column is flagged. The flags drive only the data multiplexers and the fault indication, never any sequencing logic, so the late flag arrival sits just ahead of the output register. A saturating counter totals the flagged words.

Top module: `wfm_scrub`

## Requirements
- R1: After reset, `vld_o`, `fault_o`, `wt_o` and `fault_cnt_o` are all zero.
- R2: `vld_o` equals the `vld_i` of the previous clock cycle. The masked word appears on `wt_o` one cycle after it is accepted.
- R3: Mode code 0 (pass) outputs the accepted word unchanged, whatever the flags.
- R4: Mode code 1 (word) outputs zero when any bit of `flag_i` is set. With no flag set it outputs the word unchanged.
- R5: Mode code 2 (bit) replaces every flagged bit below the top bit (bit W-1 is the sign) with the sign bit of the word read. Unflagged bits keep their value.
- R6: In mode code 2 a flag on the sign bit itself has no effect, and the sign bit as read is output.
- R7: Mode code 3 outputs zero when the sign bit's flag is set. Otherwise it behaves exactly like mode code 2.
- R8: `fault_o` is high together with a word's result when that accepted word had at least one flag set, in every mode. It is low when no word was accepted.
- R9: `fault_cnt_o` rises by one for each accepted word with at least one flag set, in any mode, and holds at its all-ones maximum. Unflagged or non-valid cycles leave it unchanged.
- R10: In a cycle with `vld_i` low, `wt_o` keeps its previous value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Weight word valid this cycle |
| mode_i | input | 2 | Masking policy: 0 pass, 1 word, 2 bit, 3 bit with sign fallback |
| wt_i | input | W | Weight word read from memory (signed fixed point) |
| flag_i | input | W | Per-bit suspected-fault flags |
| vld_o | output | 1 | Output word valid |
| wt_o | output | W | Masked weight word |
| fault_o | output | 1 | The word now on the output had at least one flag set |
| fault_cnt_o | output | CNT_W | Saturating count of flagged words |

## Verification
On every cycle the assertions check these properties: the valid latency, the hold of the output on idle cycles, zeroing in word mode, the unchanged data in pass mode, the preserved sign in bit mode, that a fault indication never appears without valid, and that the counter only moves on a flagged word and never goes down. The bench's scenarios alone show the exact bit patterns that sign substitution gives for positive and negative words, the sign-flag fallback in mode 3 and the counter's stop at its maximum. These are all compared against a reference model computed in the bench.

// File: rtl/wfm_pkg.sv
package wfm_pkg;
   typedef enum logic [1:0] {
      WFM_PASS   = 2'd0,
      WFM_WORD   = 2'd1,
      WFM_BIT    = 2'd2,
      WFM_BIT_SZ = 2'd3
   } wfm_mode_e;
endpackage

// File: rtl/wfm_bit_sub.sv
// One two-input multiplexer per bit, selected by that bit's flag; the
// sign bit itself is always passed as read.
module wfm_bit_sub #(
   parameter int W = 8
) (
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] flag_i,
   output logic [W-1:0] data_o
);
   localparam int SGN = W - 1;

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == SGN) begin : g_sign
         assign data_o[b] = data_i[b];
      end else begin : g_mag
         assign data_o[b] = flag_i[b] ? data_i[SGN] : data_i[b];
      end
   end
endmodule

// File: rtl/wfm_mode_sel.sv
module wfm_mode_sel
   import wfm_pkg::*;
#(
   parameter int W = 8
) (
   input  wfm_mode_e    mode_i,
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] flag_i,
   input  logic [W-1:0] bitsub_i,
   output logic [W-1:0] data_o,
   output logic         any_o
);
   localparam int SGN = W - 1;

   assign any_o = |flag_i;

   always_comb begin
      unique case (mode_i)
         WFM_PASS:   data_o = data_i;
         WFM_WORD:   data_o = any_o ? '0 : data_i;
         WFM_BIT:    data_o = bitsub_i;
         WFM_BIT_SZ: data_o = flag_i[SGN] ? '0 : bitsub_i;
         default:    data_o = data_i;
      endcase
   end
endmodule

// File: rtl/wfm_fault_ctr.sv
module wfm_fault_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         cnt_o <= '0;
      else if (inc_i && (cnt_o != CNT_MAX))
         cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/wfm_scrub.sv
module wfm_scrub
   import wfm_pkg::*;
#(
   parameter int W     = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             vld_i,
   input  logic [1:0]       mode_i,
   input  logic [W-1:0]     wt_i,
   input  logic [W-1:0]     flag_i,
   output logic             vld_o,
   output logic [W-1:0]     wt_o,
   output logic             fault_o,
   output logic [CNT_W-1:0] fault_cnt_o
);
   if (W < 2) begin : g_bad_w
      $error("wfm_scrub: W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("wfm_scrub: CNT_W must be at least 1");
   end

   wfm_mode_e    mode;
   logic [W-1:0] bitsub;
   logic [W-1:0] masked;
   logic         any_flag;

   assign mode = wfm_mode_e'(mode_i);

   wfm_bit_sub #(.W(W)) u_bit_sub (
      .data_i (wt_i),
      .flag_i (flag_i),
      .data_o (bitsub)
   );

   wfm_mode_sel #(.W(W)) u_mode_sel (
      .mode_i   (mode),
      .data_i   (wt_i),
      .flag_i   (flag_i),
      .bitsub_i (bitsub),
      .data_o   (masked),
      .any_o    (any_flag)
   );

   wfm_fault_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (vld_i && any_flag),
      .cnt_o  (fault_cnt_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         vld_o   <= 1'b0;
         fault_o <= 1'b0;
         wt_o    <= '0;
      end else begin
         vld_o   <= vld_i;
         fault_o <= vld_i && any_flag;
         if (vld_i)
            wt_o <= masked;
      end
   end
endmodule

// File: rtl/wfm_scrub_chk.sv
module wfm_scrub_chk #(
   parameter int W     = 8,
   parameter int CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             vld_i,
   input logic [1:0]       mode_i,
   input logic [W-1:0]     wt_i,
   input logic [W-1:0]     flag_i,
   input logic             vld_o,
   input logic [W-1:0]     wt_o,
   input logic             fault_o,
   input logic [CNT_W-1:0] fault_cnt_o
);
   logic up;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) up <= 1'b0;
      else         up <= 1'b1;
   end

   p_vld_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      up |-> (vld_o == $past(vld_i)));

   p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld_i |=> $stable(wt_o));

   p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && mode_i == 2'd0) |=> (wt_o == $past(wt_i)));

   p_word_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && mode_i == 2'd1 && (|flag_i)) |=> (wt_o == '0));

   p_sign_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && mode_i == 2'd2) |=> (wt_o[W-1] == $past(wt_i[W-1])));

   p_fault_vld_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> vld_o);

   p_cnt_still_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(vld_i && (|flag_i)) |=> $stable(fault_cnt_o));

   p_cnt_mono_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      up |-> (fault_cnt_o >= $past(fault_cnt_o)));
endmodule

bind wfm_scrub wfm_scrub_chk #(.W(W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/wfm_scrub_tb.sv
module wfm_scrub_tb_top;
   localparam int W     = 8;
   localparam int CNT_W = 4;
   localparam int CMAX  = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             vld_i;
   logic [1:0]       mode_i;
   logic [W-1:0]     wt_i;
   logic [W-1:0]     flag_i;
   logic             vld_o;
   logic [W-1:0]     wt_o;
   logic             fault_o;
   logic [CNT_W-1:0] fault_cnt_o;

   int total = 0;
   int bad   = 0;
   logic [W-1:0] exp_wt;
   int           exp_cnt;
   logic         done = 1'b0;

   always #10 clk = ~clk;

   wfm_scrub #(.W(W), .CNT_W(CNT_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .vld_i(vld_i), .mode_i(mode_i),
      .wt_i(wt_i), .flag_i(flag_i), .vld_o(vld_o), .wt_o(wt_o),
      .fault_o(fault_o), .fault_cnt_o(fault_cnt_o));

   function automatic logic [W-1:0] model(input logic [1:0] m,
                                          input logic [W-1:0] d,
                                          input logic [W-1:0] f);
      logic [W-1:0] s;
      s = d;
      for (int b = 0; b < W - 1; b++)
         if (f[b]) s[b] = d[W-1];
      case (m)
         2'd0: return d;
         2'd1: return (|f) ? '0 : d;
         2'd2: return s;
         default: return f[W-1] ? '0 : s;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic step(input string req, input logic v, input logic [1:0] m,
                       input logic [W-1:0] d, input logic [W-1:0] f);
      vld_i = v; mode_i = m; wt_i = d; flag_i = f;
      if (v) exp_wt = model(m, d, f);
      if (v && (|f) && exp_cnt < CMAX) exp_cnt++;
      @(posedge clk);
      @(negedge clk);
      chk({req, " data"}, int'(wt_o), int'(exp_wt));
      chk("R2 valid", int'(vld_o), int'(v));
      chk("R8 fault", int'(fault_o), int'(v && (|f)));
      chk("R9 count", int'(fault_cnt_o), exp_cnt);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; vld_i = 1'b0; mode_i = '0; wt_i = '0; flag_i = '0;
      exp_wt = '0; exp_cnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset vld", int'(vld_o), 0);
      chk("R1 reset wt", int'(wt_o), 0);
      chk("R1 reset cnt", int'(fault_cnt_o), 0);
      chk("R1 reset fault", int'(fault_o), 0);
      rst_n = 1'b1;

      step("R3 pass flags", 1'b1, 2'd0, 8'hA5, 8'hFF);
      step("R4 word clean", 1'b1, 2'd1, 8'h3C, 8'h00);
      step("R4 word flagged", 1'b1, 2'd1, 8'h3C, 8'h10);
      step("R5 bit neg", 1'b1, 2'd2, 8'h80, 8'h03);
      step("R5 bit pos", 1'b1, 2'd2, 8'h7F, 8'h0F);
      step("R6 sign flag", 1'b1, 2'd2, 8'h85, 8'h80);
      step("R7 sign zero", 1'b1, 2'd3, 8'h85, 8'h80);
      step("R7 like bit", 1'b1, 2'd3, 8'h80, 8'h01);
      step("R10 idle hold", 1'b0, 2'd1, 8'h55, 8'hFF);
      chk("R10 held value", int'(wt_o), 8'h81);

      for (int i = 0; i < 300; i++) begin
         logic [W-1:0] f;
         f = ($urandom % 3 == 0) ? '0 : W'($urandom);
         step("R5 random", ($urandom % 4) != 0, 2'($urandom), W'($urandom), f);
      end
      chk("R9 saturated", int'(fault_cnt_o), CMAX);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule